// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner Deserializer

This block receives a serial stream, one bit per cycle of its bit clock, in which every word is carried as a 12-bit frame. It searches for the frame boundary on its own, reports lock on an active-low output once that boundary has proved stable, and from then on presents each 10-bit payload on a parallel bus. The bus comes with a recovered word clock whose period is one frame time.

A frame is a high start bit, then ten payload bits with the least significant bit first, then a low stop bit. Because the stop bit is always 0 and the start bit is always 1, every frame boundary carries a guaranteed 0-to-1 transition. The aligner checks a candidate bit offset once per frame. When the check fails it slips its offset by one bit. An offset is accepted only after a fixed number of consecutive frames have passed. Lock can therefore be reached on a stream of dedicated sync frames or on ordinary payload traffic. After lock, a run of bad frames whose length is set at a port drops lock, and the search starts again.

A receive-enable input quiets the parallel outputs without losing lock. A power-down input clears all alignment state and forces every output quiet. A strobe-select input chooses which edge of the recovered word clock marks valid data.

Top module: `ecfa_deser`

## Requirements
- R1: A frame occupies 12 consecutive bits in this order: start bit (1), payload bits d0 to d9, stop bit (0). When a frame is captured, `data_o[k]` equals payload bit dk. A sync frame (six 1s then six 0s, counting the start and stop bits) therefore yields `data_o` = 10'h01F.
- R2: `lock_no_o` is 1 during and after reset and at all times while the block is unlocked. It is 0 while the block is locked.
- R3: Lock is acquired both from a continuous sync-frame stream and from a stream of arbitrary framed payload, whatever bit offset the stream starts at.
- R4: Lock is declared only after LOCK_FRAMES (default 8) consecutive frames have shown start=1 and stop=0 at the same candidate offset. A failed check moves the candidate offset by one bit.
- R5: While locked, each frame with valid start and stop bits updates `data_o` once. `data_o` then holds that value for a full frame time, and successive words appear in transmit order.
- R6: While locked and enabled, `word_clk_o` has a period of 12 bit clocks. With `strobe_rise_i`=1 its rising edge falls in the middle of each word's valid window. With `strobe_rise_i`=0 the clock is inverted, so its falling edge falls there instead.
- R7: While `rx_en_i`=0, `data_o`, `word_clk_o` and `out_en_o` are 0. Lock is kept during this time.
- R8: While `pwr_dn_ni`=0, all outputs are quiet and `lock_no_o` is 1 from the next clock on. Lock is acquired again after `pwr_dn_ni` returns to 1.
- R9: While locked, `loss_limit_i` consecutive frames with an invalid start or stop bit drop lock (a limit of 0 acts as 1). A shorter run of bad frames keeps lock. Invalid frames never update `data_o`.
- R10: While unlocked, `data_o` holds its last value and `word_clk_o` stays at its idle level: 0 when `strobe_rise_i`=1, 1 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one serial bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Serial data bit |
| rx_en_i | input | 1 | Output enable for data and word clock, active high |
| pwr_dn_ni | input | 1 | Power-down, active low; clears alignment state |
| strobe_rise_i | input | 1 | 1: data valid at the rising edge of word_clk_o; 0: at the falling edge |
| loss_limit_i | input | LOSS_W | Number of consecutive bad frames that drops lock |
| data_o | output | DATA_W | Recovered payload word |
| word_clk_o | output | 1 | Recovered word clock |
| lock_no_o | output | 1 | Lock indicator, low when locked |
| out_en_o | output | 1 | Pad drive enable for data_o and word_clk_o |

## Verification
A wrong phase counter or a wrong slip decision shows at the ports within one frame. The recovered words stop following the transmit sequence, or the word clock edges stop falling exactly 12 cycles apart. A wrong good-frame or bad-frame count shows as `lock_no_o` changing a frame early or late: the port is checked after 6 sync frames and again right after 2 and after 3 injected bad frames. Bit-order faults show in the first captured sync word and in every payload word after it.

// File: rtl/ecfa_pkg.sv
package ecfa_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } align_state_e;
endpackage

// File: rtl/ecfa_window.sv
module ecfa_window #(
  parameter int FRAME_W = 12,
  parameter int PH_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               ser_i,
  input  logic               slip_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [PH_W-1:0]    phase_o,
  output logic               tick_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr_q;
  logic [PH_W-1:0]    ph_q;

  assign tick_o  = run_i && (ph_q == PH_LAST);
  assign frame_o = sr_q;
  assign phase_o = ph_q;

  // sr_q[0] is the oldest bit of the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      ph_q <= '0;
    end else if (!run_i) begin
      ph_q <= '0;
    end else begin
      sr_q <= {ser_i, sr_q[FRAME_W-1:1]};
      if (tick_o) begin
        if (!slip_i) ph_q <= '0;  // slip: hold phase one extra bit
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecfa_lock.sv
module ecfa_lock
  import ecfa_pkg::*;
#(
  parameter int LOCK_FRAMES = 8,
  parameter int LOSS_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              frame_ok_i,
  input  logic [LOSS_W-1:0] loss_limit_i,
  output logic              locked_o,
  output logic              slip_o,
  output logic              capture_o
);
  localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_FRAMES - 1);

  align_state_e      st_q;
  logic [GOOD_W-1:0] good_q;
  logic [LOSS_W-1:0] bad_q;
  logic [LOSS_W:0]   bad_inc, limit;
  logic              drop;

  assign bad_inc  = {1'b0, bad_q} + 1'b1;
  assign limit    = (loss_limit_i == '0) ? (LOSS_W+1)'(1) : {1'b0, loss_limit_i};
  assign locked_o = (st_q == ST_LOCK);

  always_comb begin
    slip_o    = 1'b0;
    capture_o = 1'b0;
    drop      = 1'b0;
    if (tick_i) begin
      if (st_q == ST_LOCK) begin
        if (frame_ok_i) begin
          capture_o = 1'b1;
        end else if (bad_inc >= limit) begin
          drop   = 1'b1;
          slip_o = 1'b1;
        end
      end else if (frame_ok_i) begin
        capture_o = (good_q == GOOD_LAST);
      end else begin
        slip_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      bad_q  <= '0;
    end else if (!run_i) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      bad_q  <= '0;
    end else if (tick_i) begin
      if (st_q == ST_LOCK) begin
        if (frame_ok_i) begin
          bad_q <= '0;
        end else if (drop) begin
          st_q   <= ST_HUNT;
          good_q <= '0;
          bad_q  <= '0;
        end else begin
          bad_q <= bad_inc[LOSS_W-1:0];
        end
      end else if (frame_ok_i) begin
        if (good_q == GOOD_LAST) begin
          st_q   <= ST_LOCK;
          good_q <= '0;
          bad_q  <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end else begin
        good_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ecfa_out.sv
module ecfa_out #(
  parameter int DATA_W  = 10,
  parameter int FRAME_W = 12,
  parameter int PH_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [PH_W-1:0]    phase_i,
  input  logic               locked_i,
  input  logic               rx_en_i,
  input  logic               pwr_dn_ni,
  input  logic               strobe_rise_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               word_clk_o,
  output logic               lock_no_o,
  output logic               out_en_o
);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(FRAME_W / 2);

  logic [DATA_W-1:0] data_q;
  logic              en, clk_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= '0;
    else if (capture_i) data_q <= frame_i[DATA_W:1];
  end

  assign en         = rx_en_i && pwr_dn_ni;
  assign clk_hi     = locked_i && (phase_i >= PH_HALF);
  assign word_clk_o = en && (clk_hi ^ ~strobe_rise_i);
  assign data_o     = en ? data_q : '0;
  assign out_en_o   = en;
  assign lock_no_o  = ~locked_i;
endmodule

// File: rtl/ecfa_deser.sv
module ecfa_deser #(
  parameter int DATA_W      = 10,
  parameter int LOCK_FRAMES = 8,
  parameter int LOSS_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              rx_en_i,
  input  logic              pwr_dn_ni,
  input  logic              strobe_rise_i,
  input  logic [LOSS_W-1:0] loss_limit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              word_clk_o,
  output logic              lock_no_o,
  output logic              out_en_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int PH_W    = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frame;
  logic [PH_W-1:0]    phase;
  logic               tick, slip, capture, locked, frame_ok;

  // start bit oldest and high, stop bit newest and low
  assign frame_ok = frame[0] && !frame[FRAME_W-1];

  ecfa_window #(.FRAME_W(FRAME_W), .PH_W(PH_W)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (pwr_dn_ni),
    .ser_i   (ser_i),
    .slip_i  (slip),
    .frame_o (frame),
    .phase_o (phase),
    .tick_o  (tick)
  );

  ecfa_lock #(.LOCK_FRAMES(LOCK_FRAMES), .LOSS_W(LOSS_W)) u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (pwr_dn_ni),
    .tick_i       (tick),
    .frame_ok_i   (frame_ok),
    .loss_limit_i (loss_limit_i),
    .locked_o     (locked),
    .slip_o       (slip),
    .capture_o    (capture)
  );

  ecfa_out #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .PH_W(PH_W)) u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .capture_i     (capture),
    .frame_i       (frame),
    .phase_i       (phase),
    .locked_i      (locked),
    .rx_en_i       (rx_en_i),
    .pwr_dn_ni     (pwr_dn_ni),
    .strobe_rise_i (strobe_rise_i),
    .data_o        (data_o),
    .word_clk_o    (word_clk_o),
    .lock_no_o     (lock_no_o),
    .out_en_o      (out_en_o)
  );
endmodule

// File: rtl/ecfa_deser_chk.sv
module ecfa_deser_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              pwr_dn_ni,
  input logic              strobe_rise_i,
  input logic [DATA_W-1:0] data_o,
  input logic              word_clk_o,
  input logic              lock_no_o,
  input logic              out_en_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CW      = $clog2(FRAME_W + 2) + 1;
  localparam logic [CW-1:0] GAP_MAX = '1;

  logic          wc_q, sel_q, seen_q, ok;
  logic [CW-1:0] gap_q;

  assign ok = !lock_no_o && out_en_o && (strobe_rise_i == sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wc_q   <= 1'b0;
      sel_q  <= 1'b1;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      wc_q  <= word_clk_o;
      sel_q <= strobe_rise_i;
      if (word_clk_o && !wc_q) begin
        gap_q  <= CW'(1);
        seen_q <= ok;
      end else begin
        if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
        if (!ok) seen_q <= 1'b0;
      end
    end
  end

  assert_word_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_clk_o && !wc_q && seen_q && ok) |-> (gap_q == CW'(FRAME_W)));

  assert_disabled_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |-> (data_o == '0 && !word_clk_o && !out_en_o));

  assert_pd_drops_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_dn_ni |=> lock_no_o);

  assert_unlocked_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_no_o && rx_en_i && pwr_dn_ni) |=>
      (!lock_no_o || !rx_en_i || !pwr_dn_ni || $stable(data_o)));
endmodule

bind ecfa_deser ecfa_deser_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_en_i       (rx_en_i),
  .pwr_dn_ni     (pwr_dn_ni),
  .strobe_rise_i (strobe_rise_i),
  .data_o        (data_o),
  .word_clk_o    (word_clk_o),
  .lock_no_o     (lock_no_o),
  .out_en_o      (out_en_o)
);

// File: tb/ecfa_deser_tb.sv
module ecfa_deser_tb;
  localparam int DATA_W = 10;
  localparam int LOSS_W = 4;

  logic              clk = 1'b0;
  logic              rst_n, ser, rx_en, pwr_dn_n, rise;
  logic [LOSS_W-1:0] limit;
  logic [DATA_W-1:0] data;
  logic              wclk, lock_n, oen;

  int     n_chk = 0, n_fail = 0;
  longint cyc = 0;
  int     tx_mode = 0, tx_bad_left = 0, tx_frames = 0;
  logic [9:0] lcg = 10'h055;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  ecfa_deser #(.DATA_W(DATA_W), .LOCK_FRAMES(8), .LOSS_W(LOSS_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .rx_en_i(rx_en), .pwr_dn_ni(pwr_dn_n),
    .strobe_rise_i(rise), .loss_limit_i(limit), .data_o(data), .word_clk_o(wclk),
    .lock_no_o(lock_n), .out_en_o(oen)
  );

  function automatic logic [9:0] nxt(input logic [9:0] x);
    return 10'(32'(x) * 5 + 423);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_frame(input int k);
    wait (tx_frames >= k);
    repeat (3) @(negedge clk);
  endtask

  // collect n word strobes, check word sequence and edge spacing
  task automatic collect(input int n, input bit edge_hi);
    logic       prev_wc;
    logic [9:0] prev_w;
    bit         have;
    longint     last_t;
    int         got;
    have = 0; got = 0; last_t = 0; prev_w = '0;
    @(negedge clk);
    prev_wc = wclk;
    for (int c = 0; c < n * 14 + 40 && got < n; c++) begin
      @(negedge clk);
      if (wclk != prev_wc && wclk == edge_hi) begin
        if (have) begin
          chk(data == nxt(prev_w), "R1 R5 word sequence", data, nxt(prev_w));
          chk(cyc - last_t == 12, "R6 strobe spacing", cyc - last_t, 12);
        end
        have = 1; prev_w = data; last_t = cyc; got++;
      end
      prev_wc = wclk;
    end
    chk(got == n, "R6 strobe count", got, n);
  endtask

  // transmitter: frames bit0 (start) first
  initial begin
    ser = 1'b1;
    wait (rst_n);
    repeat (5) @(negedge clk);
    forever begin
      logic [11:0] fr;
      if (tx_bad_left > 0) begin
        fr = '0;
        tx_bad_left--;
      end else if (tx_mode == 0) begin
        fr = 12'b0000_0011_1111;
      end else begin
        fr = {1'b0, lcg, 1'b1};
        lcg = nxt(lcg);
      end
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        ser = fr[i];
      end
      tx_frames++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int         f;
    logic [9:0] keep;
    logic       wc0;
    rst_n = 0; rx_en = 1; pwr_dn_n = 1; rise = 1; limit = 4'd3;
    repeat (3) @(negedge clk);
    chk(lock_n == 1'b1, "R2 reset lock", lock_n, 1);
    chk(data == '0, "R2 reset data", data, 0);
    chk(wclk == 1'b0, "R10 reset word clock idle", wclk, 0);
    chk(oen == 1'b1, "R7 reset enable", oen, 1);
    rst_n = 1;

    wait_frame(6);
    chk(lock_n == 1'b1, "R4 no lock before 8 frames", lock_n, 1);
    wait_frame(14);
    chk(lock_n == 1'b0, "R3 lock on sync frames", lock_n, 0);
    chk(data == 10'h01F, "R1 sync word", data, 10'h01F);

    tx_mode = 1;
    wait_frame(tx_frames + 3);
    collect(10, 1'b1);

    rise = 1'b0;
    collect(8, 1'b0);
    rise = 1'b1;

    @(negedge clk) rx_en = 1'b0;
    @(negedge clk);
    chk(data == '0, "R7 data quiet", data, 0);
    chk(wclk == 1'b0, "R7 clock quiet", wclk, 0);
    chk(oen == 1'b0, "R7 enable low", oen, 0);
    repeat (30) @(negedge clk);
    chk(lock_n == 1'b0, "R7 lock kept", lock_n, 0);
    rx_en = 1'b1;
    collect(4, 1'b1);

    // two bad frames with limit 3
    f = tx_frames;
    wait (tx_frames == f + 1);
    @(negedge clk);
    f = tx_frames;
    tx_bad_left = 2;
    wait_frame(f + 1);
    keep = data;
    wait_frame(f + 3);
    chk(lock_n == 1'b0, "R9 short bad run keeps lock", lock_n, 0);
    chk(data == keep, "R9 bad frames not captured", data, keep);
    wait_frame(f + 6);

    // three bad frames drop lock
    f = tx_frames;
    wait (tx_frames == f + 1);
    @(negedge clk);
    f = tx_frames;
    tx_bad_left = 3;
    wait_frame(f + 1);
    keep = data;
    wait_frame(f + 3);
    chk(lock_n == 1'b0, "R9 lock held before limit", lock_n, 0);
    wait_frame(f + 4);
    chk(lock_n == 1'b1, "R9 lock lost at limit", lock_n, 1);
    chk(data == keep, "R10 data held", data, keep);
    wc0 = wclk;
    chk(wc0 == 1'b0, "R10 idle level rise mode", wc0, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(wclk == wc0 && data == keep, "R10 no strobe while unlocked", {wclk, data}, {wc0, keep});
    end
    rise = 1'b0;
    @(negedge clk);
    chk(wclk == 1'b1, "R10 idle level fall mode", wclk, 1);
    rise = 1'b1;

    wait_frame(tx_frames + 30);
    chk(lock_n == 1'b0, "R3 relock on payload", lock_n, 0);
    collect(5, 1'b1);

    @(negedge clk) pwr_dn_n = 1'b0;
    @(negedge clk);
    chk(lock_n == 1'b1, "R8 lock dropped", lock_n, 1);
    chk(oen == 1'b0, "R8 enable low", oen, 0);
    chk(data == '0 && wclk == 1'b0, "R8 outputs quiet", {wclk, data}, 0);
    repeat (20) @(negedge clk);
    pwr_dn_n = 1'b1;
    @(negedge clk);
    chk(lock_n == 1'b1, "R8 unlocked after release", lock_n, 1);
    wait_frame(tx_frames + 30);
    chk(lock_n == 1'b0, "R8 relock after power-down", lock_n, 0);
    collect(4, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule